// File: doc/BRIEF.md
# Instruction machine-cycle sequencer

This block steps through a small set of 8-bit instructions one bus transaction at a time. It asks an external bus cycle generator for each transaction in turn: an opcode fetch, a memory read, a memory write, an I/O read or an I/O write. It gives the kind, the address and the write data, and it waits for a completion strobe. When the strobe comes it takes the returned byte and updates its own registers: the program counter, the accumulator, a B register and a two-byte temporary address.

The opcode fixes how many operand bytes follow and whether a final data transfer ends the instruction. Operand bytes are read from consecutive addresses after the opcode. An address is gathered low byte first. An I/O port number is a single byte and appears zero-extended on the address bus. When an instruction ends, the next request is always the fetch of the following opcode.

Top module: `isa_cycle_seq`

## Requirements
- R1: While `rst` is high, `cyc_req` is low, `pc_q` equals `RESET_PC`, and `acc_q` and `b_q` are zero. The first request after reset is an opcode fetch at `RESET_PC`.
- R2: Every instruction starts with an opcode fetch (`cyc_kind` 0) at `pc_q`. `pc_q` rises by one, modulo 2^16, for each completed opcode or operand read and for nothing else.
- R3: Opcode 78h uses the fetch alone and copies `b_q` into `acc_q`.
- R4: Opcode 06h is followed by a memory read (`cyc_kind` 1) at the next address. The byte returned goes into `b_q`.
- R5: Opcode DBh is followed by a memory read of the port number and then an I/O read (`cyc_kind` 3) at address {00h, port}. The byte returned goes into `acc_q`.
- R6: Opcode D3h is followed by a memory read of the port number and then an I/O write (`cyc_kind` 4) at {00h, port}, with `cyc_wdata` equal to `acc_q`.
- R7: Opcode 3Ah is followed by two memory reads (low byte, then high byte) and then a memory read at {high, low}. The byte returned goes into `acc_q`.
- R8: Opcode 32h is followed by two memory reads (low byte, then high byte) and then a memory write (`cyc_kind` 2) at {high, low}, with `cyc_wdata` equal to `acc_q`.
- R9: Any other opcode takes the fetch alone and leaves `acc_q` and `b_q` unchanged.
- R10: A request keeps its kind and address unchanged until `cyc_done` is seen. No register changes in a cycle without completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_req | output | 1 | A bus transaction is requested |
| cyc_kind | output | 3 | 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write |
| cyc_addr | output | 16 | Transaction address |
| cyc_wdata | output | 8 | Write data (accumulator) |
| cyc_done | input | 1 | Transaction completes this cycle |
| cyc_rdata | input | 8 | Read data, valid with `cyc_done` |
| pc_q | output | 16 | Program counter |
| acc_q | output | 8 | Accumulator |
| b_q | output | 8 | B register |

## Verification
The bench builds the block with `RESET_PC` set to FFFEh. The first instructions therefore fetch their operand bytes across the 16-bit wrap of the program counter. It sweeps all 256 opcode values, so every unsupported code is exercised as well as each of the six handled ones. Operand, port and data bytes are derived from the opcode, and the number of wait cycles before each completion rotates from zero to two. This covers held requests and register stability during waits across every cycle kind.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

    localparam int DW = 8;
    localparam int AW = 2 * DW;
    localparam int NB = AW / DW;

    typedef enum logic [2:0] {
        BC_FETCH = 3'd0,
        BC_MRD   = 3'd1,
        BC_MWR   = 3'd2,
        BC_IORD  = 3'd3,
        BC_IOWR  = 3'd4
    } bus_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OPND,
        ST_XFER
    } step_e;

    localparam logic [DW-1:0] OPC_COPY_AB  = 8'h78;
    localparam logic [DW-1:0] OPC_IMM_B    = 8'h06;
    localparam logic [DW-1:0] OPC_PORT_IN  = 8'hDB;
    localparam logic [DW-1:0] OPC_PORT_OUT = 8'hD3;
    localparam logic [DW-1:0] OPC_LOAD_A   = 8'h3A;
    localparam logic [DW-1:0] OPC_STORE_A  = 8'h32;

    typedef struct packed {
        logic [1:0] n_opnd;
        logic       copy_ab;
        logic       imm_to_b;
        logic       has_xfer;
        bus_kind_e  xkind;
        logic       load_acc;
    } plan_t;

    function automatic plan_t decode_op(input logic [DW-1:0] op);
        plan_t p;
        p = '0;
        p.xkind = BC_FETCH;
        case (op)
            OPC_COPY_AB:  p.copy_ab = 1'b1;
            OPC_IMM_B: begin
                p.n_opnd   = 2'd1;
                p.imm_to_b = 1'b1;
            end
            OPC_PORT_IN: begin
                p.n_opnd   = 2'd1;
                p.has_xfer = 1'b1;
                p.xkind    = BC_IORD;
                p.load_acc = 1'b1;
            end
            OPC_PORT_OUT: begin
                p.n_opnd   = 2'd1;
                p.has_xfer = 1'b1;
                p.xkind    = BC_IOWR;
            end
            OPC_LOAD_A: begin
                p.n_opnd   = 2'd2;
                p.has_xfer = 1'b1;
                p.xkind    = BC_MRD;
                p.load_acc = 1'b1;
            end
            OPC_STORE_A: begin
                p.n_opnd   = 2'd2;
                p.has_xfer = 1'b1;
                p.xkind    = BC_MWR;
            end
            default: p = p;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/seqr_decode.sv
module seqr_decode
    import seqr_pkg::*;
(
    input  logic [DW-1:0] op,
    output plan_t         plan
);
    always_comb plan = decode_op(op);
endmodule

// File: rtl/seqr_regs.sv
module seqr_regs
    import seqr_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pc_inc,
    input  logic          acc_ld,
    input  logic [DW-1:0] acc_d,
    input  logic          b_ld,
    input  logic [DW-1:0] b_d,
    input  logic [NB-1:0] tmp_ld,
    input  logic [DW-1:0] tmp_d,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] acc,
    output logic [DW-1:0] breg,
    output logic [AW-1:0] taddr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= RESET_PC;
            acc  <= '0;
            breg <= '0;
        end else begin
            if (pc_inc) pc <= pc + 1'b1;
            if (acc_ld) acc <= acc_d;
            if (b_ld)   breg <= b_d;
        end
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)            taddr[i*DW +: DW] <= '0;
            else if (tmp_ld[i]) taddr[i*DW +: DW] <= tmp_d;
        end
    end
endmodule

// File: rtl/seqr_busgen.sv
module seqr_busgen
    import seqr_pkg::*;
(
    input  step_e         step,
    input  bus_kind_e     xkind,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] taddr,
    input  logic [DW-1:0] acc,
    output logic          req,
    output bus_kind_e     kind,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);
    always_comb begin
        req   = (step != ST_IDLE);
        kind  = BC_FETCH;
        addr  = pc;
        wdata = acc;
        case (step)
            ST_OPND: kind = BC_MRD;
            ST_XFER: begin
                kind = xkind;
                if (xkind == BC_IORD || xkind == BC_IOWR)
                    addr = AW'(taddr[DW-1:0]);
                else
                    addr = taddr;
            end
            default: kind = BC_FETCH;
        endcase
    end
endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
    import seqr_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    output logic        cyc_req,
    output logic [2:0]  cyc_kind,
    output logic [15:0] cyc_addr,
    output logic [7:0]  cyc_wdata,
    input  logic        cyc_done,
    input  logic [7:0]  cyc_rdata,
    output logic [15:0] pc_q,
    output logic [7:0]  acc_q,
    output logic [7:0]  b_q
);
    step_e         step;
    logic          idx;
    logic [DW-1:0] op_q;
    logic [DW-1:0] dec_in;
    plan_t         plan;
    bus_kind_e     kind;
    logic [AW-1:0] taddr;
    logic          hs;
    logic          pc_inc, acc_ld, b_ld;
    logic [DW-1:0] acc_d;
    logic [NB-1:0] tmp_ld;

    // Decode the byte arriving during a fetch; otherwise the held opcode.
    assign dec_in = (step == ST_FETCH) ? cyc_rdata : op_q;

    seqr_decode u_dec (.op(dec_in), .plan(plan));

    seqr_busgen u_bus (
        .step(step), .xkind(plan.xkind), .pc(pc_q), .taddr(taddr), .acc(acc_q),
        .req(cyc_req), .kind(kind), .addr(cyc_addr), .wdata(cyc_wdata)
    );
    assign cyc_kind = kind;

    assign hs     = cyc_req & cyc_done;
    assign pc_inc = hs & (step == ST_FETCH || step == ST_OPND);
    assign acc_ld = hs & ((step == ST_FETCH && plan.copy_ab) ||
                          (step == ST_XFER && plan.load_acc));
    assign acc_d  = (step == ST_FETCH) ? b_q : cyc_rdata;
    assign b_ld   = hs & (step == ST_OPND) & plan.imm_to_b;
    assign tmp_ld = {hs & (step == ST_OPND) & idx, hs & (step == ST_OPND) & ~idx};

    seqr_regs #(.RESET_PC(RESET_PC)) u_regs (
        .clk(clk), .rst(rst), .pc_inc(pc_inc),
        .acc_ld(acc_ld), .acc_d(acc_d), .b_ld(b_ld), .b_d(cyc_rdata),
        .tmp_ld(tmp_ld), .tmp_d(cyc_rdata),
        .pc(pc_q), .acc(acc_q), .breg(b_q), .taddr(taddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= ST_IDLE;
            idx  <= 1'b0;
            op_q <= '0;
        end else begin
            case (step)
                ST_IDLE: step <= ST_FETCH;
                ST_FETCH: if (hs) begin
                    op_q <= cyc_rdata;
                    idx  <= 1'b0;
                    step <= (plan.n_opnd != 2'd0) ? ST_OPND : ST_FETCH;
                end
                ST_OPND: if (hs) begin
                    if (!idx && plan.n_opnd == 2'd2) idx <= 1'b1;
                    else step <= plan.has_xfer ? ST_XFER : ST_FETCH;
                end
                ST_XFER: if (hs) step <= ST_FETCH;
                default: step <= ST_IDLE;
            endcase
        end
    end

    // R10: an outstanding request holds still until it completes
    a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
        cyc_req && !cyc_done |=> cyc_req && $stable(cyc_kind) && $stable(cyc_addr));

    // R10: registers only move on a completed transaction
    a_r10_regs_quiet: assert property (@(posedge clk) disable iff (rst)
        !(cyc_req && cyc_done) |=> $stable(acc_q) && $stable(b_q) && $stable(pc_q));

    // R2: each completed fetch or operand read advances the program counter by one
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        cyc_req && cyc_done && (step == ST_FETCH || step == ST_OPND)
        |=> pc_q == $past(pc_q) + 16'd1);

    // R2: a finished transfer is always followed by an opcode fetch at pc
    a_r2_fetch_next: assert property (@(posedge clk) disable iff (rst)
        cyc_req && cyc_done && step == ST_XFER
        |=> cyc_kind == 3'd0 && cyc_addr == pc_q);

    // R6, R8: write transactions carry the accumulator
    a_r8_wdata_acc: assert property (@(posedge clk) disable iff (rst)
        cyc_req && (cyc_kind == 3'd2 || cyc_kind == 3'd4) |-> cyc_wdata == acc_q);

    // R5, R6: port addresses have a zero upper byte
    a_r5_io_upper_zero: assert property (@(posedge clk) disable iff (rst)
        cyc_req && (cyc_kind == 3'd3 || cyc_kind == 3'd4) |-> cyc_addr[15:8] == 8'h00);

    // R1: no request while reset holds
    a_r1_quiet_reset: assert property (@(posedge clk) rst |=> !cyc_req);
endmodule

// File: tb/isa_cycle_seq_bench.sv
module isa_cycle_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_req;
    logic [2:0]  cyc_kind;
    logic [15:0] cyc_addr;
    logic [7:0]  cyc_wdata;
    logic        cyc_done = 1'b0;
    logic [7:0]  cyc_rdata = 8'h00;
    logic [15:0] pc_q;
    logic [7:0]  acc_q;
    logic [7:0]  b_q;

    localparam logic [15:0] START = 16'hFFFE;

    isa_cycle_seq #(.RESET_PC(START)) u_isa_cycle_seq (
        .clk(clk), .rst(rst), .cyc_req(cyc_req), .cyc_kind(cyc_kind),
        .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata), .cyc_done(cyc_done),
        .cyc_rdata(cyc_rdata), .pc_q(pc_q), .acc_q(acc_q), .b_q(b_q)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int wsel = 0;
    logic [15:0] m_pc;
    logic [7:0]  m_acc, m_b;

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // One bus transaction; called at a falling edge, returns at a falling edge.
    task automatic bus_cycle(input logic [2:0] ek, input logic [15:0] ea,
                             input logic [7:0] rd, input bit chk_w,
                             input logic [7:0] ew, input string rq);
        int guard = 0;
        int waits;
        while (!cyc_req && guard < 8) begin
            @(negedge clk);
            guard++;
        end
        check(cyc_req == 1'b1, rq, {31'd0, cyc_req}, 1);
        check(cyc_kind == ek, rq, {29'd0, cyc_kind}, {29'd0, ek});
        check(cyc_addr == ea, rq, {16'd0, cyc_addr}, {16'd0, ea});
        if (chk_w) check(cyc_wdata == ew, rq, {24'd0, cyc_wdata}, {24'd0, ew});
        waits = wsel % 3;
        wsel++;
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            // R10: request held and registers unchanged while waiting
            check(cyc_req && cyc_kind == ek && cyc_addr == ea, "R10",
                  {16'd0, cyc_addr}, {16'd0, ea});
            check(pc_q == m_pc && acc_q == m_acc && b_q == m_b, "R10",
                  {pc_q, acc_q, b_q}, {m_pc, m_acc, m_b});
        end
        cyc_rdata = rd;
        cyc_done  = 1'b1;
        @(negedge clk);
        cyc_done  = 1'b0;
        cyc_rdata = 8'h00;
    endtask

    task automatic run_instr(input logic [7:0] op, input logic [7:0] x1,
                             input logic [7:0] x2, input logic [7:0] xd);
        bus_cycle(3'd0, m_pc, op, 1'b0, 8'h00, "R2");
        m_pc = m_pc + 16'd1;
        case (op)
            8'h78: m_acc = m_b;  // R3
            8'h06: begin         // R4
                bus_cycle(3'd1, m_pc, x1, 1'b0, 8'h00, "R4");
                m_pc = m_pc + 16'd1;
                m_b = x1;
            end
            8'hDB: begin         // R5
                bus_cycle(3'd1, m_pc, x1, 1'b0, 8'h00, "R5");
                m_pc = m_pc + 16'd1;
                bus_cycle(3'd3, {8'h00, x1}, xd, 1'b0, 8'h00, "R5");
                m_acc = xd;
            end
            8'hD3: begin         // R6
                bus_cycle(3'd1, m_pc, x1, 1'b0, 8'h00, "R6");
                m_pc = m_pc + 16'd1;
                bus_cycle(3'd4, {8'h00, x1}, 8'h00, 1'b1, m_acc, "R6");
            end
            8'h3A: begin         // R7
                bus_cycle(3'd1, m_pc, x1, 1'b0, 8'h00, "R7");
                m_pc = m_pc + 16'd1;
                bus_cycle(3'd1, m_pc, x2, 1'b0, 8'h00, "R7");
                m_pc = m_pc + 16'd1;
                bus_cycle(3'd1, {x2, x1}, xd, 1'b0, 8'h00, "R7");
                m_acc = xd;
            end
            8'h32: begin         // R8
                bus_cycle(3'd1, m_pc, x1, 1'b0, 8'h00, "R8");
                m_pc = m_pc + 16'd1;
                bus_cycle(3'd1, m_pc, x2, 1'b0, 8'h00, "R8");
                m_pc = m_pc + 16'd1;
                bus_cycle(3'd2, {x2, x1}, 8'h00, 1'b1, m_acc, "R8");
            end
            default: ;           // R9: nothing beyond the fetch
        endcase
        check(pc_q == m_pc, "R2", {16'd0, pc_q}, {16'd0, m_pc});
        check(acc_q == m_acc, "R9", {24'd0, acc_q}, {24'd0, m_acc});
        check(b_q == m_b, "R9", {24'd0, b_q}, {24'd0, m_b});
    endtask

    initial begin
        m_pc = START;
        m_acc = 8'h00;
        m_b = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cyc_req == 1'b0, "R1", {31'd0, cyc_req}, 0);
        check(pc_q == START, "R1", {16'd0, pc_q}, {16'd0, START});
        check(acc_q == 8'h00 && b_q == 8'h00, "R1", {acc_q, b_q}, 0);
        rst = 1'b0;
        @(negedge clk);

        // Directed program, first bytes cross the pc wrap
        run_instr(8'h06, 8'h43, 8'h00, 8'h00);
        run_instr(8'h78, 8'h00, 8'h00, 8'h00);
        check(acc_q == 8'h43, "R3", {24'd0, acc_q}, 32'h43);
        run_instr(8'hD3, 8'h07, 8'h00, 8'h00);
        run_instr(8'h32, 8'h6A, 8'h52, 8'h00);
        run_instr(8'hDB, 8'hC0, 8'h00, 8'h5E);
        run_instr(8'h3A, 8'hFF, 8'h10, 8'hC7);
        run_instr(8'h00, 8'h00, 8'h00, 8'h00);

        // Full opcode sweep with derived operand bytes
        for (int k = 0; k < 256; k++) begin
            logic [7:0] op;
            op = k[7:0];
            run_instr(op, op ^ 8'hA5, ~op, op * 8'd3 + 8'd1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule